// File: doc/BRIEF.md
# Dual Chip-Select Bus Strobe Decoder

This block sits between a processor's asynchronous parallel bus and the clocked logic of a converter. The bus has two chip selects, a read pin and a write pin. Once all pins are synchronised, the block decodes them into one internal read strobe and one internal write strobe. A read strobe issues a single pop to the sample FIFO and drives the FIFO word onto the output data bus for as long as it lasts. A write strobe loads the input data bus into one of two control registers, chosen by an address pin, at the moment the strobe ends.

A mode input selects one of two pin conventions. In the first, separate read and write pins are used. In the second, the write pin is a combined read/write direction line and the read pin is the data strobe, which suits processors with a single read/write output. Chip select 0 is active low and chip select 1 is active high, so the part can be decoded from two address lines without glue logic. Each strobe begins when the last of its qualifying pins becomes valid and ends as soon as the first of them goes inactive.

Top module: `bus_strobe_decoder`

## Requirements
- R1: In separate mode (rw_mode_i=0), a read access requires sel_n_i=0, sel_i=1, rd_n_i=0 and wr_n_i=1 together. Such an access raises fifo_pop_o once and then rdata_oe_o.
- R2: In separate mode, a write access requires sel_n_i=0, sel_i=1, wr_n_i=0 and rd_n_i=1. When the strobe ends, wdata_i is loaded into ctrl0_o if addr_i=0 or into ctrl1_o if addr_i=1, and the other register keeps its value.
- R3: If sel_n_i is high or sel_i is low, a read or write access has no effect. There is no pop, no output enable and no register change.
- R4: fifo_pop_o is high for exactly one cycle per read strobe, however long the strobe lasts. rdata_oe_o rises in the cycle after that pop and falls after the strobe ends.
- R5: In separate mode, if rd_n_i and wr_n_i are both low, neither a read nor a write takes place.
- R6: In combined mode (rw_mode_i=1), rd_n_i is the data strobe and wr_n_i gives the direction. wr_n_i=1 makes the access a read and wr_n_i=0 makes it a write, each qualified by both chip selects.
- R7: Every pin passes through SYNC_STAGES flip-flops before decoding. With the default of 2, fifo_pop_o is high after the second rising clock edge following the pins becoming valid, and not before.
- R8: rdata_o equals fifo_word_i while rdata_oe_o is high and is zero otherwise.
- R9: After reset, ctrl0_o and ctrl1_o are zero and fifo_pop_o and rdata_oe_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_n_i | input | 1 | Chip select 0, active low |
| sel_i | input | 1 | Chip select 1, active high |
| rd_n_i | input | 1 | Read pin, active low; data strobe in combined mode |
| wr_n_i | input | 1 | Write pin, active low; direction (1 = read) in combined mode |
| rw_mode_i | input | 1 | 0 = separate read/write pins, 1 = combined read/write pin |
| addr_i | input | 1 | Control register select |
| wdata_i | input | DATA_W | Data written into a control register |
| fifo_word_i | input | DATA_W | Word at the head of the sample FIFO |
| rdata_o | output | DATA_W | Output data bus value |
| rdata_oe_o | output | 1 | Output data driver enable |
| fifo_pop_o | output | 1 | One-cycle FIFO pop strobe |
| ctrl0_o | output | DATA_W | Control register 0 |
| ctrl1_o | output | DATA_W | Control register 1 |

## Verification
The bench builds the block with DATA_W=8 and SYNC_STAGES=2. With these values the latency can be checked edge by edge: the pop is expected at exactly the second rising edge after the pins change. The 8-bit width lets distinct patterns such as 0xA5, 0x3C and 0xFF separate writes to the two registers and show up any cross-talk between them. Read strobes of one cycle and of many cycles cover the single-pop rule at both extremes.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;
  typedef struct packed {
    logic sel_n;
    logic sel;
    logic rd_n;
    logic wr_n;
  } pins_t;

  localparam pins_t PINS_IDLE = '{sel_n: 1'b1, sel: 1'b0, rd_n: 1'b1, wr_n: 1'b1};
endpackage

// File: rtl/bus_pin_sync.sv
module bus_pin_sync #(
  parameter int         WIDTH   = 4,
  parameter int         STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bus_strobe_decode.sv
module bus_strobe_decode
  import bus_dec_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  pins_t pins_i,
  input  logic  rw_mode_i,
  output logic  rd_act_o,
  output logic  pop_o,
  output logic  wr_done_o
);
  logic cs_ok, rd_now, wr_now;
  logic rd_q, wr_q;

  assign cs_ok = !pins_i.sel_n && pins_i.sel;

  always_comb begin
    if (rw_mode_i) begin
      // rd_n is the strobe, wr_n carries direction (1 = read)
      rd_now = cs_ok && !pins_i.rd_n &&  pins_i.wr_n;
      wr_now = cs_ok && !pins_i.rd_n && !pins_i.wr_n;
    end else begin
      rd_now = cs_ok && !pins_i.rd_n &&  pins_i.wr_n;
      wr_now = cs_ok && !pins_i.wr_n &&  pins_i.rd_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_now;
      wr_q <= wr_now;
    end
  end

  assign pop_o     = rd_now && !rd_q;
  assign wr_done_o = wr_q && !wr_now;
  assign rd_act_o  = rd_q;

  p_pop_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> !pop_o);
endmodule

// File: rtl/bus_ctrl_regs.sv
module bus_ctrl_regs #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 2,
  localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_done_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_o[i] <= '0;
      else if (wr_done_i && addr_i == ADDR_W'(i))    regs_o[i] <= wdata_i;
    end
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_done_i |=> $stable(regs_o));
endmodule

// File: rtl/bus_strobe_decoder.sv
module bus_strobe_decoder
  import bus_dec_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_n_i,
  input  logic              sel_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic              rw_mode_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] fifo_word_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              fifo_pop_o,
  output logic [DATA_W-1:0] ctrl0_o,
  output logic [DATA_W-1:0] ctrl1_o
);
  localparam int NUM_REGS = 2;
  localparam int PIN_W    = $bits(pins_t);

  pins_t pins_raw, pins_s;
  logic  wr_done;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  assign pins_raw = '{sel_n: sel_n_i, sel: sel_i, rd_n: rd_n_i, wr_n: wr_n_i};

  bus_pin_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  bus_strobe_decode u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pins_i   (pins_s),
    .rw_mode_i(rw_mode_i),
    .rd_act_o (rdata_oe_o),
    .pop_o    (fifo_pop_o),
    .wr_done_o(wr_done)
  );

  bus_ctrl_regs #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_done_i(wr_done),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .regs_o   (regs)
  );

  assign ctrl0_o = regs[0];
  assign ctrl1_o = regs[1];
  assign rdata_o = rdata_oe_o ? fifo_word_i : '0;

  p_oe_after_pop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> rdata_oe_o);
  p_oe_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdata_oe_o) |-> $past(fifo_pop_o));
  p_no_mix_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> !wr_done);
endmodule

// File: tb/sim_bus_strobe_decoder.sv
`timescale 1ns/1ps
module sim_bus_strobe_decoder;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, sel = 1'b0, rd_n = 1'b1, wr_n = 1'b1, rw_mode = 1'b0, addr = 1'b0;
  logic [DW-1:0] wdata = '0, fifo_word = '0;
  logic [DW-1:0] rdata, ctrl0, ctrl1;
  logic oe, pop;

  int total = 0, bad = 0, pop_cnt = 0;
  logic oe_prev = 1'b0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] m0 = '0, m1 = '0;

  always #2.5 clk = ~clk;

  bus_strobe_decoder #(.DATA_W(DW), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_n_i(sel_n), .sel_i(sel), .rd_n_i(rd_n),
    .wr_n_i(wr_n), .rw_mode_i(rw_mode), .addr_i(addr), .wdata_i(wdata),
    .fifo_word_i(fifo_word), .rdata_o(rdata), .rdata_oe_o(oe), .fifo_pop_o(pop),
    .ctrl0_o(ctrl0), .ctrl1_o(ctrl1)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: pop counting, output bus checks against expected queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (pop) pop_cnt++;
      if (oe && !oe_prev) begin
        if (exp_q.size() == 0) chk(1'b0, "R1 unexpected read", 32'(rdata), 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(rdata == e, "R8 read data", 32'(rdata), 32'(e));
        end
      end
      if (!oe && rdata != '0) chk(1'b0, "R8 bus not zero", 32'(rdata), 0);
      oe_prev = oe;
    end
  end

  task automatic idle();
    sel_n = 1'b1; sel = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic do_read(input logic cs0_n, input logic cs1, input logic [DW-1:0] w,
                         input int hold, input bit hit, input string req);
    int p0;
    p0 = pop_cnt;
    fifo_word = w;
    if (hit) exp_q.push_back(w);
    @(negedge clk);
    sel_n = cs0_n; sel = cs1; wr_n = 1'b1; rd_n = 1'b0;
    repeat (hold) @(negedge clk);
    idle();
    repeat (6) @(negedge clk);
    #1;
    chk(pop_cnt - p0 == (hit ? 1 : 0), req, 32'(pop_cnt - p0), hit ? 1 : 0);
    chk(!oe, {req, " oe released"}, 32'(oe), 0);
  endtask

  task automatic do_write(input logic cs0_n, input logic cs1, input logic a,
                          input logic [DW-1:0] d, input bit hit, input string req);
    @(negedge clk);
    addr = a; wdata = d; sel_n = cs0_n; sel = cs1;
    if (rw_mode) begin
      wr_n = 1'b0;
      @(negedge clk);
      rd_n = 1'b0;
    end else wr_n = 1'b0;
    repeat (3) @(negedge clk);
    if (rw_mode) rd_n = 1'b1; else wr_n = 1'b1;
    @(negedge clk);
    idle();
    repeat (6) @(negedge clk);
    #1;
    if (hit) begin
      if (a) m1 = d; else m0 = d;
    end
    chk(ctrl0 == m0, {req, " ctrl0"}, 32'(ctrl0), 32'(m0));
    chk(ctrl1 == m1, {req, " ctrl1"}, 32'(ctrl1), 32'(m1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    #1;
    chk(ctrl0 == 0 && ctrl1 == 0, "R9 reset regs", 32'({ctrl0, ctrl1}), 0);
    chk(!oe && !pop, "R9 reset strobes", 32'({oe, pop}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 latency, edge by edge
    fifo_word = 8'h5A; exp_q.push_back(8'h5A);
    sel_n = 1'b0; sel = 1'b1; rd_n = 1'b0;
    @(negedge clk); #1;
    chk(!pop, "R7 no pop after one edge", 32'(pop), 0);
    @(negedge clk); #1;
    chk(pop, "R7 pop after second edge", 32'(pop), 1);
    @(negedge clk); #1;
    chk(!pop && oe, "R4 pop ends, oe on", 32'({pop, oe}), 32'(2'b01));
    idle();
    repeat (6) @(negedge clk);

    // R1 / R4 reads of different length
    do_read(1'b0, 1'b1, 8'hC3, 1,  1'b1, "R1 short read");
    do_read(1'b0, 1'b1, 8'h81, 20, 1'b1, "R4 long read single pop");
    // R3 chip selects invalid
    do_read(1'b1, 1'b1, 8'h11, 4, 1'b0, "R3 read cs0 high");
    do_read(1'b0, 1'b0, 8'h22, 4, 1'b0, "R3 read cs1 low");

    // R2 writes
    do_write(1'b0, 1'b1, 1'b0, 8'hA5, 1'b1, "R2 write reg0");
    do_write(1'b0, 1'b1, 1'b1, 8'h3C, 1'b1, "R2 write reg1");
    do_write(1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, "R3 write cs0 high");
    do_write(1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, "R3 write cs1 low");

    // R5 clash: both direction pins low
    p0 = pop_cnt;
    @(negedge clk);
    addr = 1'b0; wdata = 8'h77; sel_n = 1'b0; sel = 1'b1; rd_n = 1'b0; wr_n = 1'b0;
    repeat (5) @(negedge clk);
    idle();
    repeat (6) @(negedge clk); #1;
    chk(pop_cnt == p0, "R5 clash no pop", 32'(pop_cnt - p0), 0);
    chk(ctrl0 == m0 && ctrl1 == m1, "R5 clash no write", 32'({ctrl0, ctrl1}), 32'({m0, m1}));

    // R6 combined mode
    rw_mode = 1'b1;
    @(negedge clk);
    do_read(1'b0, 1'b1, 8'h96, 3, 1'b1, "R6 rw read");
    do_write(1'b0, 1'b1, 1'b0, 8'h0F, 1'b1, "R6 rw write reg0");
    do_write(1'b0, 1'b1, 1'b1, 8'hE1, 1'b1, "R6 rw write reg1");
    do_read(1'b1, 1'b1, 8'h44, 3, 1'b0, "R6 rw read cs invalid");
    rw_mode = 1'b0;
    @(negedge clk);
    do_read(1'b0, 1'b1, 8'h7E, 2, 1'b1, "R1 read after mode return");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all expected reads seen", 32'(exp_q.size()), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule